// File: doc/BRIEF.md
# External Memory Bus Controller

This block sits between an on-chip master and an external memory bus. The master raises a request with a byte address, a write flag, sixteen bits of write data and two byte enables. The block turns that request into one or two external bus cycles and pulses a done flag when the last cycle is in recovery. On a read, the data assembled from the bus is ready at that same moment.

The external bus is 16 or 8 bits wide, chosen by a static width input. Address and data can use separate pins, or the address can be time-shared on the low data lanes during a latch-enable pulse. Two write-strobe schemes are offered. In the split scheme there is one strobe for each byte lane. In the combined scheme there is one write strobe plus a byte-high enable. The combined scheme is always used on the 8-bit bus.

Four chip selects decode the top two address bits. A ready input stretches the strobe phase. A hold request makes the block release the bus between transactions.

Top module: `ebi_ctrl`

## Requirements
- R1: During and just after reset the block is idle. All strobes and chip selects are high (inactive), the latch enable is low, hold-acknowledge is high, done is low, and the address and control output enables are high.
- R2: A bus cycle lasts one cycle of address phase, then the strobe phase, then one recovery cycle. The latch enable is high only in the address phase, and no strobe is low in the address or recovery phase. The address output holds the cycle's byte address. Done is high exactly in the recovery cycle of a transaction's last bus cycle.
- R3: The ready input is sampled at the end of every strobe-phase cycle. Each low sample keeps the strobe phase, with its strobes low, for one more cycle, so N low samples give N+1 strobe cycles.
- R4: In split-strobe mode (16-bit bus, strobe_comb_i=0), a write drives wr_lo_n_o low for the low lane (even byte address) and wr_hi_n_o low for the high lane (odd byte address). A word write to an even address drives both low. A read drives only rd_n_o low.
- R5: In combined-strobe mode, wr_lo_n_o is the single write strobe and goes low in the strobe phase of every write. wr_hi_n_o is the byte-high enable: it is low for the whole cycle when the high lane is used, and it is never used as a strobe.
- R6: With width8_i=1 the combined scheme is used whatever strobe_comb_i says. The byte-high enable then follows address bit 0 of the cycle.
- R7: In multiplexed mode the address phase drives d_o[7:0] with d_oe_o=2'b01. The value is address bits 7..0 on the 8-bit bus and address bits 8..1 on the 16-bit bus.
- R8: Byte enable bit 0 selects the byte at addr_i (wdata_i[7:0] / rdata_o[7:0]), and bit 1 selects the byte at addr_i+1 (bits 15:8). An enable value of zero is treated as 2'b01. On the 16-bit bus, an even address moves byte data on lane D[7:0] and an odd address on lane D[15:8]. A word access to an odd address is split into two cycles: addr_i first, then addr_i+1. Bytes that are not enabled read back as zero.
- R9: On the 8-bit bus every byte takes its own cycle on D[7:0]: the byte at addr_i first, then the byte at addr_i+1.
- R10: cs_n_o[k] is low for the whole bus cycle exactly when address bits 19:18 equal k. At most one chip select is low at any time.
- R11: The hold request is granted only from idle. Hold-acknowledge goes low in the cycle after the idle clock edge that sees hold_n_i low. In hold, a_oe_o, ctl_oe_o and d_oe_o are all zero, and no request is started. A hold raised during a transaction waits until that transaction is done.
- R12: In separate-bus mode a read never enables the data outputs. A write enables only its used lanes, and only in the strobe and recovery phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Transaction request, held until done |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Byte address of the first byte |
| wdata_i | input | 16 | Write data (byte at addr_i in bits 7:0) |
| be_i | input | 2 | Byte enables for addr_i and addr_i+1 |
| rdata_o | output | 16 | Assembled read data |
| done_o | output | 1 | High in recovery of the last bus cycle |
| width8_i | input | 1 | Static bus width: 1 = 8-bit, 0 = 16-bit |
| mux_mode_i | input | 1 | Static: 1 = address on shared data lanes |
| strobe_comb_i | input | 1 | Strobe scheme for the 16-bit bus: 1 = combined |
| rdy_n_i | input | 1 | Active-low ready; low adds a wait cycle |
| hold_n_i | input | 1 | Active-low bus hold request |
| hlda_n_o | output | 1 | Active-low hold acknowledge |
| a_o | output | 20 | External address |
| a_oe_o | output | 1 | Output enable for a_o |
| d_i | input | 16 | External data in |
| d_o | output | 16 | External data out (also the shared address) |
| d_oe_o | output | 2 | Output enables, bit 0 low lane, bit 1 high lane |
| cs_n_o | output | 4 | Active-low chip selects |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_lo_n_o | output | 1 | Low-lane write strobe, or the single write strobe |
| wr_hi_n_o | output | 1 | High-lane write strobe, or the byte-high enable |
| ale_o | output | 1 | Address latch enable |
| ctl_oe_o | output | 1 | Output enable for strobes, chip selects and latch enable |

## Verification
Some properties are checked on every cycle:
- a low ready sample always keeps the strobe phase;
- hold is entered only from idle;
- done is followed by idle or a new address phase;
- the read and write strobes never overlap, and neither overlaps the latch enable;
- at most one chip select is active.

Other behaviour can only be shown by the bench's scenarios:
- the exact strobe pattern for each width, scheme and address parity;
- where byte data sits on the lanes, and how odd word accesses split;
- the value placed on the shared lines in multiplexed mode;
- the number of wait cycles;
- the assembled read data;
- the timing of a hold that is raised during a transaction.

// File: rtl/ebi_pkg.sv
// Shared types for the external bus controller.
// Assumes a 16-bit internal data path split into two byte lanes.
package ebi_pkg;
    localparam int BYTE_W = 8;
    localparam int DATA_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_STRB,
        PH_REC,
        PH_HOLD
    } ebi_phase_e;
endpackage

// File: rtl/ebi_seq.sv
// Bus cycle sequencer. It captures a request, splits it into byte or word
// bus cycles, steps each cycle through the address, strobe and recovery
// phases, inserts wait cycles while ready is low, grants hold from idle,
// and assembles read data.
// Assumes width8_i is static and req_i is held until done_o.
module ebi_seq
    import ebi_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [1:0]             be_i,
    input  logic                   width8_i,
    input  logic                   rdy_n_i,
    input  logic                   hold_n_i,
    input  logic [DATA_W-1:0]      d_i,
    output ebi_phase_e             phase_o,
    output logic [ADDR_W-1:0]      cur_addr_o,
    output logic                   lane_lo_o,
    output logic                   lane_hi_o,
    output logic                   we_o,
    output logic [DATA_W-1:0]      cur_wdata_o,
    output logic [DATA_W-1:0]      rdata_o,
    output logic                   done_o
);
    ebi_phase_e          ph_q, ph_d;
    logic [ADDR_W-1:0]   base_q;
    logic                we_q;
    logic [DATA_W-1:0]   wd_q;
    logic [1:0]          need_q;
    logic [DATA_W-1:0]   rd_q;
    logic                word_c;
    logic                b0_c;
    logic [1:0]          clr_c;
    logic [1:0]          left_c;
    logic [BYTE_W-1:0]   lane_byte;
    logic                start_c;

    // Pick the current piece of the request: a word, the first byte or the second byte.
    always_comb begin
        b0_c       = need_q[0];
        word_c     = need_q[0] & need_q[1] & ~width8_i & ~base_q[0];
        cur_addr_o = b0_c ? base_q : base_q + ADDR_W'(1);
        clr_c      = word_c ? 2'b11 : (b0_c ? 2'b01 : 2'b10);
        left_c     = need_q & ~clr_c;
        lane_lo_o  = width8_i | word_c | ~cur_addr_o[0];
        lane_hi_o  = ~width8_i & (word_c | cur_addr_o[0]);
        if (word_c)
            cur_wdata_o = wd_q;
        else if (b0_c)
            cur_wdata_o = {wd_q[BYTE_W-1:0], wd_q[BYTE_W-1:0]};
        else
            cur_wdata_o = {wd_q[DATA_W-1:BYTE_W], wd_q[DATA_W-1:BYTE_W]};
        lane_byte = lane_hi_o ? d_i[DATA_W-1:BYTE_W] : d_i[BYTE_W-1:0];
    end

    assign start_c = (ph_q == PH_IDLE) && hold_n_i && req_i;

    // Phase transitions.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: if (!hold_n_i) ph_d = PH_HOLD;
                     else if (req_i) ph_d = PH_ADDR;
            PH_ADDR: ph_d = PH_STRB;
            PH_STRB: if (rdy_n_i) ph_d = PH_REC;
            PH_REC:  ph_d = (left_c != 2'b00) ? PH_ADDR : PH_IDLE;
            PH_HOLD: if (hold_n_i) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Request capture and tracking of the bytes still to be moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            we_q   <= 1'b0;
            wd_q   <= '0;
            need_q <= 2'b00;
        end else if (start_c) begin
            base_q <= addr_i;
            we_q   <= we_i;
            wd_q   <= wdata_i;
            need_q <= (be_i == 2'b00) ? 2'b01 : be_i;
        end else if (ph_q == PH_REC) begin
            need_q <= left_c;
        end
    end

    // Read data assembly at the end of the strobe phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (start_c)
            rd_q <= '0;
        else if (ph_q == PH_STRB && rdy_n_i && !we_q) begin
            if (word_c)    rd_q <= d_i;
            else if (b0_c) rd_q[BYTE_W-1:0] <= lane_byte;
            else           rd_q[DATA_W-1:BYTE_W] <= lane_byte;
        end
    end

    assign phase_o = ph_q;
    assign we_o    = we_q;
    assign rdata_o = rd_q;
    assign done_o  = (ph_q == PH_REC) && (left_c == 2'b00);

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_STRB && !rdy_n_i) |=> (ph_q == PH_STRB));
    // R11
    hold_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_HOLD && $past(ph_q) != PH_HOLD) |-> ($past(ph_q) == PH_IDLE));
    // R2
    done_then_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (ph_q == PH_IDLE || ph_q == PH_ADDR));
endmodule

// File: rtl/ebi_pins.sv
// Pin driver. It derives the strobes, the latch enable, the shared-lane
// address, the data lane enables and the bus release during hold from the
// current phase and piece.
// Assumes width8_i, mux_i and comb_cfg_i are static while a transaction runs.
module ebi_pins
    import ebi_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  ebi_phase_e             phase_i,
    input  logic [ADDR_W-1:0]      cur_addr_i,
    input  logic                   lane_lo_i,
    input  logic                   lane_hi_i,
    input  logic                   we_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic                   width8_i,
    input  logic                   mux_i,
    input  logic                   comb_cfg_i,
    output logic                   active_o,
    output logic [ADDR_W-1:0]      a_o,
    output logic                   a_oe_o,
    output logic [DATA_W-1:0]      d_o,
    output logic [1:0]             d_oe_o,
    output logic                   rd_n_o,
    output logic                   wr_lo_n_o,
    output logic                   wr_hi_n_o,
    output logic                   ale_o,
    output logic                   ctl_oe_o,
    output logic                   hlda_n_o
);
    logic              strb, comb, bhe, wphase, aphase, held;
    logic [BYTE_W-1:0] mux_addr;

    // Phase decode and strobe scheme selection.
    always_comb begin
        aphase   = (phase_i == PH_ADDR);
        strb     = (phase_i == PH_STRB);
        held     = (phase_i == PH_HOLD);
        active_o = aphase | strb | (phase_i == PH_REC);
        comb     = width8_i | comb_cfg_i;
        bhe      = width8_i ? cur_addr_i[0] : lane_hi_i;
        wphase   = we_i & (strb | (phase_i == PH_REC));
        mux_addr = width8_i ? cur_addr_i[BYTE_W-1:0] : cur_addr_i[BYTE_W:1];
    end

    // Strobe outputs for both schemes.
    always_comb begin
        rd_n_o    = ~(strb & ~we_i);
        wr_lo_n_o = comb ? ~(strb & we_i) : ~(strb & we_i & lane_lo_i);
        wr_hi_n_o = comb ? ~(active_o & bhe) : ~(strb & we_i & lane_hi_i);
        ale_o     = aphase;
    end

    // Address, data lanes and release during hold.
    always_comb begin
        a_o       = cur_addr_i;
        a_oe_o    = ~held;
        ctl_oe_o  = ~held;
        hlda_n_o  = ~held;
        d_oe_o[0] = (aphase & mux_i) | (wphase & lane_lo_i);
        d_oe_o[1] = wphase & lane_hi_i;
        d_o       = (aphase & mux_i) ? {{BYTE_W{1'b0}}, mux_addr} : wdata_i;
    end

    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_lo_n_o));
    // R2
    ale_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> (rd_n_o && wr_lo_n_o));
endmodule

// File: rtl/ebi_csdec.sv
// Chip-select decoder. The top address bits pick one of CS_N external
// spaces while a bus cycle is active.
// Assumes CS_N is a power of two that is no larger than 2**ADDR_W.
module ebi_csdec #(
    parameter int ADDR_W = 20,
    parameter int CS_N   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [CS_N-1:0]     cs_n_o
);
    localparam int SEL_W = $clog2(CS_N);

    logic [SEL_W-1:0] sel;
    assign sel = addr_i[ADDR_W-1 -: SEL_W];

    // One active-low select per external space.
    for (genvar k = 0; k < CS_N; k++) begin : g_cs
        assign cs_n_o[k] = ~(active_i && (sel == SEL_W'(k)));
    end

    // R10
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));
endmodule

// File: rtl/ebi_ctrl.sv
// External memory bus controller top. It connects the sequencer, the pin
// driver and the chip-select decoder.
// Assumes all inputs are synchronous to clk.
module ebi_ctrl
    import ebi_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CS_N   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [1:0]          be_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                done_o,
    input  logic                width8_i,
    input  logic                mux_mode_i,
    input  logic                strobe_comb_i,
    input  logic                rdy_n_i,
    input  logic                hold_n_i,
    output logic                hlda_n_o,
    output logic [ADDR_W-1:0]   a_o,
    output logic                a_oe_o,
    input  logic [DATA_W-1:0]   d_i,
    output logic [DATA_W-1:0]   d_o,
    output logic [1:0]          d_oe_o,
    output logic [CS_N-1:0]     cs_n_o,
    output logic                rd_n_o,
    output logic                wr_lo_n_o,
    output logic                wr_hi_n_o,
    output logic                ale_o,
    output logic                ctl_oe_o
);
    ebi_phase_e          phase;
    logic [ADDR_W-1:0]   cur_addr;
    logic                lane_lo, lane_hi, cyc_we, active;
    logic [DATA_W-1:0]   cur_wdata;

    ebi_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i),
        .width8_i(width8_i), .rdy_n_i(rdy_n_i), .hold_n_i(hold_n_i),
        .d_i(d_i), .phase_o(phase), .cur_addr_o(cur_addr),
        .lane_lo_o(lane_lo), .lane_hi_o(lane_hi), .we_o(cyc_we),
        .cur_wdata_o(cur_wdata), .rdata_o(rdata_o), .done_o(done_o)
    );

    ebi_pins #(.ADDR_W(ADDR_W)) pins_i (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .cur_addr_i(cur_addr),
        .lane_lo_i(lane_lo), .lane_hi_i(lane_hi), .we_i(cyc_we),
        .wdata_i(cur_wdata), .width8_i(width8_i), .mux_i(mux_mode_i),
        .comb_cfg_i(strobe_comb_i), .active_o(active), .a_o(a_o),
        .a_oe_o(a_oe_o), .d_o(d_o), .d_oe_o(d_oe_o), .rd_n_o(rd_n_o),
        .wr_lo_n_o(wr_lo_n_o), .wr_hi_n_o(wr_hi_n_o), .ale_o(ale_o),
        .ctl_oe_o(ctl_oe_o), .hlda_n_o(hlda_n_o)
    );

    ebi_csdec #(.ADDR_W(ADDR_W), .CS_N(CS_N)) csdec_i (
        .clk(clk), .rst_n(rst_n), .active_i(active), .addr_i(cur_addr),
        .cs_n_o(cs_n_o)
    );
endmodule

// File: tb/ebi_ctrl_tb_top.sv
// Scoreboard bench for ebi_ctrl. The driver task pushes one expected item per
// bus cycle. The monitor pops an item at each latch-enable cycle and compares
// the address, strobe and recovery phases, and it drives ready.
module ebi_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = 2'b00;
    logic [15:0] rdata;
    logic        done;
    logic        w8 = 1'b0, mux = 1'b0, comb = 1'b0;
    logic        rdy_n = 1'b1, hold_n = 1'b1;
    logic        hlda_n, a_oe, ale, ctl_oe, rd_n, wl_n, wh_n;
    logic [19:0] a;
    logic [15:0] d_in, d_out;
    logic [1:0]  d_oe;
    logic [3:0]  cs_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] memb(input logic [19:0] x);
        return x[7:0] ^ x[15:8] ^ 8'h5A;
    endfunction

    assign d_in = w8 ? {8'h00, memb(a)} : {memb({a[19:1], 1'b1}), memb({a[19:1], 1'b0})};

    ebi_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .done_o(done),
        .width8_i(w8), .mux_mode_i(mux), .strobe_comb_i(comb),
        .rdy_n_i(rdy_n), .hold_n_i(hold_n), .hlda_n_o(hlda_n), .a_o(a),
        .a_oe_o(a_oe), .d_i(d_in), .d_o(d_out), .d_oe_o(d_oe), .cs_n_o(cs_n),
        .rd_n_o(rd_n), .wr_lo_n_o(wl_n), .wr_hi_n_o(wh_n), .ale_o(ale),
        .ctl_oe_o(ctl_oe)
    );

    typedef struct {
        logic [19:0] a;
        logic [3:0]  cs;
        logic [7:0]  mv;
        logic        rd, wl, wh, awh;
        logic [1:0]  doe, aoe;
        logic [7:0]  dlo, dhi;
        logic        lo, hi, we;
        int          waits;
        bit          last;
        string       tag;
    } cyc_t;

    cyc_t exp_q[$];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Driver: builds the expected bus cycles, then runs the request handshake.
    task automatic xfer(input logic w, input logic [19:0] ad, input logic [15:0] wd,
                        input logic [1:0] b, input int waits);
        logic [1:0]  nd;
        logic [15:0] er;
        int          n;
        nd = (b == 2'b00) ? 2'b01 : b;
        er = '0;
        if (nd[0]) er[7:0]  = memb(ad);
        if (nd[1]) er[15:8] = memb(ad + 20'd1);
        while (nd != 2'b00) begin
            cyc_t c;
            logic wrd, cmb, bh;
            logic [7:0] sb;
            wrd = (nd == 2'b11) && !w8 && !ad[0];
            c.a = nd[0] ? ad : ad + 20'd1;
            sb = nd[0] ? wd[7:0] : wd[15:8];
            c.lo = w8 || wrd || !c.a[0];
            c.hi = !w8 && (wrd || c.a[0]);
            c.we = w;
            cmb = w8 || comb;
            bh = w8 ? c.a[0] : c.hi;
            c.cs = ~(4'b0001 << c.a[19:18]);
            c.mv = w8 ? c.a[7:0] : c.a[8:1];
            c.aoe = mux ? 2'b01 : 2'b00;
            c.awh = cmb ? !bh : 1'b1;
            c.rd = w;
            c.wl = w ? (cmb ? 1'b0 : !c.lo) : 1'b1;
            c.wh = cmb ? !bh : (w ? !c.hi : 1'b1);
            c.doe = w ? {c.hi, c.lo} : 2'b00;
            c.dlo = wrd ? wd[7:0] : sb;
            c.dhi = wrd ? wd[15:8] : sb;
            c.waits = waits;
            c.last = 0;
            c.tag = cmb ? (w8 ? "R6" : "R5") : "R4";
            exp_q.push_back(c);
            nd = wrd ? 2'b00 : (nd[0] ? (nd & 2'b10) : 2'b00);
        end
        exp_q[exp_q.size()-1].last = 1;
        @(negedge clk);
        req = 1'b1; we = w; addr = ad; wdata = wd; be = b;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 200);
        chk("R2", "done seen", {31'd0, done}, 32'd1);
        if (!w) chk("R8", "rdata", {16'd0, rdata}, {16'd0, er});
        req = 1'b0;
    endtask

    // Monitor: pops one expected item per latch-enable cycle and drives ready.
    initial begin
        forever begin
            @(negedge clk);
            if (ale === 1'b1) begin
                cyc_t e;
                int j;
                if (exp_q.size() == 0) begin
                    chk("R2", "unexpected bus cycle", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R2", "address", {12'd0, a}, {12'd0, e.a});
                    chk("R10", "chip select", {28'd0, cs_n}, {28'd0, e.cs});
                    chk("R7", "addr-phase d_oe", {30'd0, d_oe}, {30'd0, e.aoe});
                    if (mux) chk("R7", "shared address", {24'd0, d_out[7:0]}, {24'd0, e.mv});
                    chk(e.tag, "addr-phase strobes", {29'd0, rd_n, wl_n, wh_n}, {29'd0, 2'b11, e.awh});
                    j = 0;
                    forever begin
                        @(negedge clk);
                        chk(e.tag, "strobes", {29'd0, rd_n, wl_n, wh_n}, {29'd0, e.rd, e.wl, e.wh});
                        chk("R10", "strobe cs", {28'd0, cs_n}, {28'd0, e.cs});
                        chk("R12", "strobe d_oe", {30'd0, d_oe}, {30'd0, e.doe});
                        if (e.we && e.lo) chk("R8", "low lane data", {24'd0, d_out[7:0]}, {24'd0, e.dlo});
                        if (e.we && e.hi) chk("R8", "high lane data", {24'd0, d_out[15:8]}, {24'd0, e.dhi});
                        if (j < e.waits) begin
                            rdy_n = 1'b0;
                            j++;
                        end else begin
                            rdy_n = 1'b1;
                            break;
                        end
                    end
                    @(negedge clk);
                    chk("R3", "recovery strobes", {29'd0, rd_n, wl_n, wh_n}, {29'd0, 2'b11, e.awh});
                    chk("R2", "recovery ale", {31'd0, ale}, 32'd0);
                    chk("R12", "recovery d_oe", {30'd0, d_oe}, {30'd0, e.doe});
                    chk("R2", "done in recovery", {31'd0, done}, {31'd0, e.last});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk("R2", "watchdog expired", 32'd1, 32'd0);
        summary();
        $finish;
    end

    // Scenarios.
    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset outputs", {22'd0, rd_n, wl_n, wh_n, cs_n, ale, hlda_n, done},
            {22'd0, 3'b111, 4'hF, 1'b0, 1'b1, 1'b0});
        chk("R1", "reset enables", {30'd0, a_oe, ctl_oe}, 32'd3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", {25'd0, rd_n, wl_n, wh_n, ale, hlda_n, done, d_oe[0]},
            {25'd0, 3'b111, 1'b0, 1'b1, 1'b0, 1'b0});

        // 16-bit, separate bus, split strobes (R4, R12, R8)
        xfer(1'b1, 20'h01230, 16'hBEEF, 2'b11, 0);
        xfer(1'b1, 20'h41234, 16'h00A5, 2'b01, 0);
        xfer(1'b1, 20'h81235, 16'h003C, 2'b01, 1);
        xfer(1'b0, 20'hC0246, 16'h0000, 2'b11, 2);   // R3 waits
        xfer(1'b0, 20'h00357, 16'h0000, 2'b01, 0);
        xfer(1'b0, 20'h40358, 16'h0000, 2'b10, 0);   // R8 upper byte only
        xfer(1'b0, 20'h40360, 16'h0000, 2'b00, 0);   // R8 zero enables
        // R8 odd word split
        xfer(1'b1, 20'h81001, 16'h1234, 2'b11, 0);
        xfer(1'b0, 20'hC1003, 16'h0000, 2'b11, 1);

        // 16-bit combined strobes (R5)
        comb = 1'b1;
        xfer(1'b1, 20'h02000, 16'hCAFE, 2'b11, 0);
        xfer(1'b1, 20'h42002, 16'h0011, 2'b01, 0);
        xfer(1'b0, 20'h82005, 16'h0000, 2'b01, 0);

        // 8-bit bus forces combined (R6, R9)
        comb = 1'b0; w8 = 1'b1;
        xfer(1'b1, 20'h43010, 16'h7788, 2'b11, 0);
        xfer(1'b0, 20'hC3021, 16'h0000, 2'b11, 1);
        xfer(1'b1, 20'h03033, 16'h0099, 2'b01, 0);

        // Multiplexed mode, both widths (R7)
        mux = 1'b1;
        xfer(1'b0, 20'h845A7, 16'h0000, 2'b01, 0);
        w8 = 1'b0;
        xfer(1'b1, 20'h045A6, 16'h5566, 2'b11, 0);
        xfer(1'b0, 20'hC5A51, 16'h0000, 2'b11, 0);
        mux = 1'b0;

        // R11 hold from idle blocks a request
        @(negedge clk);
        hold_n = 1'b0;
        @(negedge clk);
        chk("R11", "hold ack", {31'd0, hlda_n}, 32'd0);
        chk("R11", "released enables", {28'd0, a_oe, ctl_oe, d_oe}, 32'd0);
        fork
            xfer(1'b1, 20'h06000, 16'h0102, 2'b11, 0);
            begin
                repeat (4) begin
                    @(negedge clk);
                    chk("R11", "no cycle in hold", {31'd0, ale}, 32'd0);
                end
                hold_n = 1'b1;
            end
        join
        chk("R11", "hold released", {31'd0, hlda_n}, 32'd1);

        // R11 hold raised mid-transaction waits for done
        fork
            xfer(1'b0, 20'h87001, 16'h0000, 2'b11, 1);
            begin
                do @(negedge clk); while (ale !== 1'b1);
                hold_n = 1'b0;
                do begin
                    @(negedge clk);
                    chk("R11", "no hold mid-transaction", {31'd0, hlda_n}, 32'd1);
                end while (done !== 1'b1);
            end
        join
        @(negedge clk);
        chk("R11", "idle before grant", {31'd0, hlda_n}, 32'd1);
        @(negedge clk);
        chk("R11", "grant after done", {31'd0, hlda_n}, 32'd0);
        hold_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2", "scoreboard empty", exp_q.size(), 32'd0);
        summary();
        $finish;
    end
endmodule